// File: doc/BRIEF.md
# Byte-Lane Random Port with Command Register

This block is the random-access side of a 4K x 16 buffer memory. A host uses chip enable, command select, read/write, output enable and two byte-lane enables to reach one of two targets. With chip enable low and command select high, the host reads or writes the word array. With chip enable high and command select low, the host reads or writes a small command register. The sequential side of the buffer uses that register as its configuration.

Writes take effect on the rising clock edge. Read data and the per-lane output enables follow the inputs combinationally, which models the asynchronous read path. Tri-state drivers are modelled as one output enable per byte lane. A lane that is not driven shows zero on `rdata`.

The command register is 12 bits wide. Its low byte is written through the lower lane and bits 11:8 through the upper lane. On reads, bit 12 of the data returns a status bit supplied by the sequential logic, and bits 15:13 read as zero.

Top module: `rp_random_port`

## Requirements
- R1: When ce_n=0, cmd_n=1, rw=1 and oe_n=0, lane_oe[0] equals !lb_n and lane_oe[1] equals !ub_n. In the same cycle, each driven lane of rdata shows the array word at addr: lane 0 is bits 7:0 and lane 1 is bits 15:8. This holds up to the top address 0xFFF.
- R2: When ce_n=0, cmd_n=1 and rw=0, the rising clock edge writes only the enabled lanes of wdata into the array word at addr. Disabled lanes keep their old bytes, and lane_oe is 00 throughout the write.
- R3: When oe_n=1, lane_oe is 00 and rdata is 0. The port stays selected.
- R4: When lb_n=1 and ub_n=1, nothing is written to either target and lane_oe is 00.
- R5: When ce_n=1 and cmd_n=1, the port is deselected: no write takes place and lane_oe is 00.
- R6: When ce_n=1, cmd_n=0 and rw=0, the rising edge writes the command register. The lower lane stores wdata[7:0] into bits 7:0, and the upper lane stores wdata[11:8] into bits 11:8. wdata[15:12] is ignored. cmd_cfg shows the new value after that edge.
- R7: When ce_n=1, cmd_n=0, rw=1 and oe_n=0, rdata[11:0] returns the command register, rdata[12] returns seq_status and rdata[15:13] is 0. Each lane is driven only if its enable is low.
- R8: Bit 12 of the command view is read-only. Writing wdata[12]=1 never changes it, and it always follows seq_status.
- R9: When ce_n=0 and cmd_n=0, the combination is invalid. Neither the array nor the command register is written, and lane_oe is 00.
- R10: While rst_n is low, cmd_cfg is 0. The array holds no reset value.
- R11: Array writes leave the command register unchanged, and command-register writes leave the array unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes occur on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ce_n | input | 1 | Chip enable, active low |
| cmd_n | input | 1 | Command select, active low (selects the command register) |
| rw | input | 1 | 1 = read, 0 = write |
| oe_n | input | 1 | Output enable, active low |
| lb_n | input | 1 | Lower byte lane enable (bits 7:0), active low |
| ub_n | input | 1 | Upper byte lane enable (bits 15:8), active low |
| addr | input | 12 | Array word address |
| wdata | input | 16 | Write data |
| seq_status | input | 1 | Status bit from the sequential logic, read as bit 12 |
| rdata | output | 16 | Read data; undriven lanes read 0 |
| lane_oe | output | 2 | Per-lane output drive enable: bit 0 lower, bit 1 upper |
| cmd_cfg | output | 12 | Command register contents |

## Verification
The bench runs single-lane array writes and reads the whole word back. A design that applied the write mask to the wrong lane, or wrote both lanes, would return corrupted neighbouring bytes.

It also issues writes under each non-writing control combination and reads the word back afterwards. These combinations are both lanes off, full deselect and the invalid ce_n=0/cmd_n=0 case. A decoder that treated any of them as a write would expose itself there.

For the command register, the bench checks the following:
- wdata[15:12] is ignored.
- Bit 12 tracks seq_status rather than written data.
- Lane writes are isolated from each other.
- The two targets do not cross-write.

A design that stored bit 12, or decoded a command access as an array access, would fail these reads.

// File: rtl/rp_pkg.sv
package rp_pkg;
  localparam int LANE_W = 8;

  typedef enum logic [2:0] {
    ACC_IDLE   = 3'd0,
    ACC_ARR_RD = 3'd1,
    ACC_ARR_WR = 3'd2,
    ACC_CMD_RD = 3'd3,
    ACC_CMD_WR = 3'd4
  } acc_e;
endpackage

// File: rtl/rp_decode.sv
module rp_decode
  import rp_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_n,
  input  logic             cmd_n,
  input  logic             rw,
  input  logic             oe_n,
  input  logic [LANES-1:0] be_n,
  output acc_e             mode,
  output logic [LANES-1:0] arr_we,
  output logic [LANES-1:0] cmd_we,
  output logic [LANES-1:0] lane_oe
);
  logic [LANES-1:0] lane_en;
  logic             arr_sel;
  logic             cmd_sel;

  always_comb begin
    lane_en = ~be_n;
    arr_sel = !ce_n && cmd_n;
    cmd_sel = ce_n && !cmd_n;
    mode    = ACC_IDLE;
    if (arr_sel && (lane_en != '0)) begin
      mode = rw ? ACC_ARR_RD : ACC_ARR_WR;
    end else if (cmd_sel && (lane_en != '0)) begin
      mode = rw ? ACC_CMD_RD : ACC_CMD_WR;
    end
  end

  always_comb begin
    arr_we  = '0;
    cmd_we  = '0;
    lane_oe = '0;
    unique case (mode)
      ACC_ARR_WR: arr_we = lane_en;
      ACC_CMD_WR: cmd_we = lane_en;
      ACC_ARR_RD,
      ACC_CMD_RD: lane_oe = oe_n ? '0 : lane_en;
      default: ;
    endcase
  end

  // R4
  all_lanes_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&be_n) |-> (arr_we == '0 && cmd_we == '0 && lane_oe == '0));

  // R2
  no_drive_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rw) |-> (lane_oe == '0));
endmodule

// File: rtl/rp_array.sv
module rp_array
  import rp_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int LANES  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LANES-1:0]        we,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int WORD_W = LANES * LANE_W;

  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [WORD_W-1:0] word_d;
  logic              word_en;

  assign rdata   = mem_q[addr];
  assign word_en = |we;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_comb begin
      word_d[g*LANE_W +: LANE_W] = we[g] ? wdata[g*LANE_W +: LANE_W]
                                         : rdata[g*LANE_W +: LANE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (word_en) begin
      mem_q[addr] <= word_d;
    end
  end

  // R2
  lane0_written_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we[0] |=> (addr != $past(addr) || rdata[LANE_W-1:0] == $past(wdata[LANE_W-1:0])));

  // R2
  lane0_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!we[0] && we[1]) |=> (addr != $past(addr) || rdata[LANE_W-1:0] == $past(rdata[LANE_W-1:0])));
endmodule

// File: rtl/rp_cmd_reg.sv
module rp_cmd_reg
  import rp_pkg::*;
#(
  parameter int CFG_W = 12,
  parameter int LANES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LANES-1:0]        we,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [CFG_W-1:0]        cfg_q
);
  logic [CFG_W-1:0] cfg_d;
  logic             cfg_en;

  assign cfg_en = |we;

  for (genvar i = 0; i < CFG_W; i++) begin : g_bit
    always_comb begin
      cfg_d[i] = we[i / LANE_W] ? wdata[i] : cfg_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (cfg_en) begin
      cfg_q <= cfg_d;
    end
  end

  // R6
  low_lane_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we[0] |=> (cfg_q[LANE_W-1:0] == $past(wdata[LANE_W-1:0])));

  // R11
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we == '0) |=> $stable(cfg_q));
endmodule

// File: rtl/rp_random_port.sv
module rp_random_port
  import rp_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16,
  parameter int CFG_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              cmd_n,
  input  logic              rw,
  input  logic              oe_n,
  input  logic              lb_n,
  input  logic              ub_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              seq_status,
  output logic [DATA_W-1:0] rdata,
  output logic [1:0]        lane_oe,
  output logic [CFG_W-1:0]  cmd_cfg
);
  localparam int LANES  = DATA_W / LANE_W;
  localparam int PAD_W  = DATA_W - CFG_W - 1;

  logic              rst_meta_q;
  logic              rst_sync_q;
  acc_e              mode;
  logic [LANES-1:0]  be_n;
  logic [LANES-1:0]  arr_we;
  logic [LANES-1:0]  cmd_we;
  logic [LANES-1:0]  oe_lanes;
  logic [DATA_W-1:0] arr_rdata;
  logic [DATA_W-1:0] cmd_view;
  logic [DATA_W-1:0] src_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign be_n = {ub_n, lb_n};

  rp_decode #(.LANES(LANES)) u_decode (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .ce_n    (ce_n),
    .cmd_n   (cmd_n),
    .rw      (rw),
    .oe_n    (oe_n),
    .be_n    (be_n),
    .mode    (mode),
    .arr_we  (arr_we),
    .cmd_we  (cmd_we),
    .lane_oe (oe_lanes)
  );

  rp_array #(.ADDR_W(ADDR_W), .LANES(LANES)) u_array (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .we    (arr_we),
    .addr  (addr),
    .wdata (wdata),
    .rdata (arr_rdata)
  );

  rp_cmd_reg #(.CFG_W(CFG_W), .LANES(LANES)) u_cmd (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .we    (cmd_we),
    .wdata (wdata),
    .cfg_q (cmd_cfg)
  );

  assign cmd_view = {{PAD_W{1'b0}}, seq_status, cmd_cfg};
  assign src_data = (mode == ACC_CMD_RD) ? cmd_view : arr_rdata;
  assign lane_oe  = oe_lanes;

  for (genvar g = 0; g < LANES; g++) begin : g_out
    assign rdata[g*LANE_W +: LANE_W] = oe_lanes[g] ? src_data[g*LANE_W +: LANE_W]
                                                   : '0;
  end

  // R3
  oe_float_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    oe_n |-> (lane_oe == 2'b00 && rdata == '0));

  // R5
  deselect_float_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (ce_n && cmd_n) |-> (lane_oe == 2'b00));

  // R9
  invalid_sel_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (!ce_n && !cmd_n) |=> $stable(cmd_cfg));

  // R8
  status_bit_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (ce_n && !cmd_n && rw && lane_oe[1]) |-> (rdata[CFG_W] == seq_status));

  // R7
  cmd_pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (ce_n && !cmd_n) |-> (rdata[DATA_W-1:CFG_W+1] == '0));
endmodule

// File: tb/tb_rp_random_port.sv
module tb_rp_random_port;
  localparam int CLK_P = 10;
  localparam int NV    = 28;

  logic        clk;
  logic        rst_n;
  logic        ce_n, cmd_n, rw, oe_n, lb_n, ub_n;
  logic [11:0] addr;
  logic [15:0] wdata;
  logic        seq_status;
  logic [15:0] rdata;
  logic [1:0]  lane_oe;
  logic [11:0] cmd_cfg;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // {ctrl: ce_n cmd_n rw oe_n lb_n ub_n, addr, wdata, status, exp_oe, exp_rdata, req}
  localparam logic [56:0] VEC [0:NV-1] = '{
    {6'b010000, 12'h001, 16'hA5C3, 1'b0, 2'b00, 16'h0000, 4'd2},  // R2 full write
    {6'b011000, 12'h001, 16'h0000, 1'b0, 2'b11, 16'hA5C3, 4'd1},  // R1 read both
    {6'b010001, 12'h001, 16'h1234, 1'b0, 2'b00, 16'h0000, 4'd2},  // R2 lower only
    {6'b011000, 12'h001, 16'h0000, 1'b0, 2'b11, 16'hA534, 4'd2},  // R2 upper kept
    {6'b010010, 12'h001, 16'h7788, 1'b0, 2'b00, 16'h0000, 4'd2},  // R2 upper only
    {6'b011000, 12'h001, 16'h0000, 1'b0, 2'b11, 16'h7734, 4'd2},  // R2 lower kept
    {6'b011001, 12'h001, 16'h0000, 1'b0, 2'b01, 16'h0034, 4'd1},  // R1 lower read
    {6'b011010, 12'h001, 16'h0000, 1'b0, 2'b10, 16'h7700, 4'd1},  // R1 upper read
    {6'b011100, 12'h001, 16'h0000, 1'b0, 2'b00, 16'h0000, 4'd3},  // R3 outputs off
    {6'b010011, 12'h001, 16'hFFFF, 1'b0, 2'b00, 16'h0000, 4'd4},  // R4 no lanes
    {6'b011000, 12'h001, 16'h0000, 1'b0, 2'b11, 16'h7734, 4'd4},  // R4 unchanged
    {6'b110000, 12'h001, 16'hFFFF, 1'b0, 2'b00, 16'h0000, 4'd5},  // R5 deselected
    {6'b011000, 12'h001, 16'h0000, 1'b0, 2'b11, 16'h7734, 4'd5},  // R5 unchanged
    {6'b000000, 12'h001, 16'hABCD, 1'b0, 2'b00, 16'h0000, 4'd9},  // R9 invalid
    {6'b011000, 12'h001, 16'h0000, 1'b0, 2'b11, 16'h7734, 4'd9},  // R9 unchanged
    {6'b100000, 12'h001, 16'hF9A6, 1'b0, 2'b00, 16'h0000, 4'd6},  // R6 cmd write
    {6'b101000, 12'h001, 16'h0000, 1'b0, 2'b11, 16'h09A6, 4'd8},  // R8 bit12 not stored
    {6'b101000, 12'h001, 16'h0000, 1'b1, 2'b11, 16'h19A6, 4'd7},  // R7 status shown
    {6'b100001, 12'h001, 16'h1F55, 1'b1, 2'b00, 16'h0000, 4'd6},  // R6 lower lane
    {6'b101000, 12'h001, 16'h0000, 1'b1, 2'b11, 16'h1955, 4'd6},  // R6 upper kept
    {6'b100010, 12'h001, 16'h0312, 1'b0, 2'b00, 16'h0000, 4'd6},  // R6 upper lane
    {6'b101001, 12'h001, 16'h0000, 1'b0, 2'b01, 16'h0055, 4'd7},  // R7 lower read
    {6'b101010, 12'h001, 16'h0000, 1'b1, 2'b10, 16'h1300, 4'd7},  // R7 upper read
    {6'b101100, 12'h001, 16'h0000, 1'b1, 2'b00, 16'h0000, 4'd7},  // R7 outputs off
    {6'b011000, 12'h001, 16'h0000, 1'b0, 2'b11, 16'h7734, 4'd11}, // R11 array intact
    {6'b010000, 12'hFFF, 16'h0BAD, 1'b0, 2'b00, 16'h0000, 4'd2},  // R2 top address
    {6'b101000, 12'h001, 16'h0000, 1'b0, 2'b11, 16'h0355, 4'd11}, // R11 cmd intact
    {6'b011000, 12'hFFF, 16'h0000, 1'b0, 2'b11, 16'h0BAD, 4'd1}   // R1 top address
  };

  rp_random_port dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cmd_n(cmd_n), .rw(rw),
    .oe_n(oe_n), .lb_n(lb_n), .ub_n(ub_n), .addr(addr), .wdata(wdata),
    .seq_status(seq_status), .rdata(rdata), .lane_oe(lane_oe), .cmd_cfg(cmd_cfg)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    {ce_n, cmd_n, rw, oe_n, lb_n, ub_n} = 6'b111111;
    addr = '0; wdata = '0; seq_status = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0;
    idle();
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 cfg in reset", {4'h0, cmd_cfg}, 16'h0000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    {ce_n, cmd_n, rw, oe_n, lb_n, ub_n} = 6'b101000;
    #(CLK_P/4);
    check("R10 cmd read after reset", rdata, 16'h0000);
    check("R10 lanes driven", {14'h0, lane_oe}, 16'h0003);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {ce_n, cmd_n, rw, oe_n, lb_n, ub_n} = VEC[i][56:51];
      addr       = VEC[i][50:39];
      wdata      = VEC[i][38:23];
      seq_status = VEC[i][22];
      #(CLK_P/4);
      check($sformatf("R%0d vec%0d lane_oe", VEC[i][3:0], i), {14'h0, lane_oe}, {14'h0, VEC[i][21:20]});
      check($sformatf("R%0d vec%0d rdata", VEC[i][3:0], i), rdata, VEC[i][19:4]);
    end

    @(negedge clk);
    idle();
    #(CLK_P/4);
    // R6 register port view
    check("R6 cmd_cfg port", {4'h0, cmd_cfg}, 16'h0355);
    check("R5 idle lanes", {14'h0, lane_oe}, 16'h0000);

    // R10 asynchronous reset mid-run
    rst_n = 1'b0;
    #1;
    check("R10 async clear", {4'h0, cmd_cfg}, 16'h0000);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 cleared after release", {4'h0, cmd_cfg}, 16'h0000);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 5000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule